// File: doc/BRIEF.md
# USB Hub Repeater Core with Low-Speed Gating

This block is the connectivity core of a hub with one upstream port and four downstream ports. It runs on the 12 MHz bit clock. It receives the decoded line state of every port as a two-bit code, plus two one-cycle strobes from the serial engine: one marks a low-speed preamble packet identifier (the 4-bit code 1100, sent as the byte 0x3C), and one marks a received start-of-frame token. It decides in each cycle which ports drive, in which direction, and whether the low-speed drivers are used. The line state it repeats comes out one clock after it was sampled.

Traffic from the host starts a downstream session. The upstream line state is copied to every enabled, attached full-speed port. Low-speed ports stay silent until a preamble has been seen. After that they also receive the traffic, with their low-speed drivers selected, until the end-of-packet that follows. When the host is quiet, the first enabled downstream port that leaves its idle level opens an upstream session. That port alone is repeated toward the host until its end-of-packet and one further quiet bit. A frame timer counts bit clocks and restarts on every start-of-frame.

Top module: `hub_repeater`

## Requirements
- R1: In reset, and in any cycle with no session, no port drives, no low-speed driver is selected, the repeated line rests at 2'b10, and the frame count is 0 while reset is held.
- R2: Line codes are {D+, D-}: 2'b10 means D+ high, 2'b01 means D- high, 2'b00 means SE0. While a port's enable is low and no session is open, the port is classified every cycle: SE0 means nothing attached, D- high means low speed, any other code means full speed. While the port is enabled, its classification is held. Downstream port i uses bits [2i+1:2i] of the downstream line bus, and bit i of the per-port vectors.
- R3: When no session is open and the upstream line leaves 2'b10, a downstream session opens. From the next clock on, the repeated line equals the upstream line sampled one cycle earlier, and every enabled, attached full-speed port drives.
- R4: Without a preamble, a low-speed port neither drives nor has its low-speed driver selected during a downstream session.
- R5: A preamble strobe during a downstream session makes every enabled, attached low-speed port drive, with its low-speed select set, from the next clock on (within four bit times). The full-speed ports keep driving.
- R6: An end-of-packet is at least two consecutive SE0 samples followed by the source's idle level. That idle sample is still repeated. On the following clock all drivers turn off and the low-speed gate closes, so the next packet reaches no low-speed port unless it has its own preamble. A single SE0 sample followed by the idle level does not end the session.
- R7: When no session is open, an enabled, attached downstream port whose line differs from its own idle level (2'b10 for full speed, 2'b01 for low speed) opens an upstream session. From the next clock on, the upstream port drives the owner's line and no downstream port drives.
- R8: If several ports leave idle in the same cycle, the lowest-numbered port becomes the owner. Other ports are ignored until the owner's session ends.
- R9: After the owner's end-of-packet, one cycle follows in which nothing drives and no new session may open. Sessions may open again in the cycle after that.
- R10: If the host and a downstream port leave idle in the same cycle, the downstream direction wins.
- R11: The frame count rises by one every clock. It reads 0 in the cycle after a start-of-frame strobe, and wraps from FRAME_LEN-1 back to 0.
- R12: A preamble strobe that arrives while no downstream session is open has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| upLine | input | 2 | Decoded upstream line state {D+, D-} |
| dnLine | input | 8 | Decoded downstream line states, port i at bits [2i+1:2i] |
| portEn | input | 4 | Per-port enable from the hub controller |
| preStrobe | input | 1 | One-cycle pulse: preamble packet identifier received |
| sofStrobe | input | 1 | One-cycle pulse: start-of-frame token received |
| upDrive | output | 1 | Upstream port drives the repeated line |
| dnDrive | output | 4 | Per-port downstream drive enable |
| lsSel | output | 4 | Per-port low-speed driver select |
| repLine | output | 2 | Repeated line state |
| frameCnt | output | 14 | Frame timer value |

## Verification
The assertions assume the following about the inputs:
- The preamble strobe lasts one cycle and arrives only inside host traffic.
- Enabled ports stay attached.
- The code 2'b11 never appears.

Under these assumptions they check two things: the low-speed gate opens only after a strobe, and it is never open outside a downstream session. The directed stimulus keeps to these rules. It classifies ports only while they are disabled, raises the preamble strobe for one cycle, and closes every packet with two SE0 samples and an idle bit before the next scenario starts. The one exception is a deliberate stray preamble, sent while no session is open, to show that it is ignored.

// File: rtl/hubRptPkg.sv
package hubRptPkg;
  localparam int NUM_DN = 4;
  localparam int IDX_W  = $clog2(NUM_DN);

  typedef logic [1:0] line_t;
  localparam line_t LINE_SE0 = 2'b00;
  localparam line_t LINE_DMH = 2'b01;  // D- high
  localparam line_t LINE_DPH = 2'b10;  // D+ high

  // Selection and mask strobes from control to datapath, valid in the current cycle
  typedef struct packed {
    logic              actDown;
    logic              actUp;
    logic [IDX_W-1:0]  srcIdx;
    line_t             srcIdle;
    logic [NUM_DN-1:0] dnMask;
    logic [NUM_DN-1:0] lsMask;
  } ctlStrobe_t;
endpackage

// File: rtl/hubRptCtrl.sv
module hubRptCtrl
  import hubRptPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  line_t             upLine,
  input  logic [2*NUM_DN-1:0] dnLine,
  input  logic [NUM_DN-1:0] portEn,
  input  logic              preStrobe,
  input  logic              eop,
  output ctlStrobe_t        ctl
);
  typedef enum logic [1:0] {S_IDLE, S_DOWN, S_UP, S_TAIL} sess_t;

  sess_t sess, sessNext;
  logic [IDX_W-1:0]  owner, firstIdx, srcIdx;
  logic [NUM_DN-1:0] attached, isLs, leaving, enMask, lsMaskC;
  logic lsOpen, lsGate, startDown, startUp, actDown, actUp;
  line_t portLine [NUM_DN];
  line_t idleLvl  [NUM_DN];

  assign enMask = attached & portEn;

  for (genvar gi = 0; gi < NUM_DN; gi++) begin : g_port
    assign portLine[gi] = dnLine[2*gi +: 2];
    assign idleLvl[gi]  = isLs[gi] ? LINE_DMH : LINE_DPH;
    assign leaving[gi]  = enMask[gi] && (portLine[gi] != idleLvl[gi]);
  end

  // lowest index wins
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_DN - 1; i >= 0; i--)
      if (leaving[i]) firstIdx = IDX_W'(i);
  end

  assign startDown = (sess == S_IDLE) && (upLine != LINE_DPH);
  assign startUp   = (sess == S_IDLE) && !startDown && (|leaving);
  assign actDown   = (sess == S_DOWN) || startDown;
  assign actUp     = (sess == S_UP) || startUp;
  assign lsGate    = actDown && (lsOpen || preStrobe);
  assign srcIdx    = startUp ? firstIdx : owner;
  assign lsMaskC   = lsGate ? (enMask & isLs) : '0;

  always_comb begin
    ctl.actDown = actDown;
    ctl.actUp   = actUp;
    ctl.srcIdx  = srcIdx;
    ctl.srcIdle = actUp ? idleLvl[srcIdx] : LINE_DPH;
    ctl.lsMask  = lsMaskC;
    ctl.dnMask  = actDown ? ((enMask & ~isLs) | lsMaskC) : '0;
  end

  always_comb begin
    sessNext = sess;
    unique case (sess)
      S_IDLE: if (startDown) sessNext = S_DOWN;
              else if (startUp) sessNext = S_UP;
      S_DOWN: if (eop) sessNext = S_IDLE;
      S_UP:   if (eop) sessNext = S_TAIL;
      S_TAIL: sessNext = S_IDLE;
      default: sessNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sess     <= S_IDLE;
      owner    <= '0;
      lsOpen   <= 1'b0;
      attached <= '0;
      isLs     <= '0;
    end else begin
      sess   <= sessNext;
      lsOpen <= lsGate && !eop;
      if (startUp) owner <= firstIdx;
      for (int i = 0; i < NUM_DN; i++) begin
        if (sess == S_IDLE && !portEn[i]) begin
          attached[i] <= (portLine[i] != LINE_SE0);
          isLs[i]     <= (portLine[i] == LINE_DMH);
        end
      end
    end
  end

  AST_LS_NEEDS_PRE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsOpen) |-> $past(preStrobe));                          // R5
  AST_LS_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (sess != S_DOWN) |-> !lsOpen);                                // R6
  AST_EOP_ENDS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (sess == S_DOWN && eop) |=> (sess == S_IDLE));                // R6
  AST_TAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (sess == S_TAIL) |=> (sess == S_IDLE));                       // R9
  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (sess == S_UP) |=> (sess != S_UP || $stable(owner)));         // R8
endmodule

// File: rtl/hubRptData.sv
module hubRptData
  import hubRptPkg::*;
#(
  parameter int FRAME_LEN = 12000,
  localparam int FRAME_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  line_t             upLine,
  input  logic [2*NUM_DN-1:0] dnLine,
  input  logic              sofStrobe,
  input  ctlStrobe_t        ctl,
  output logic              eop,
  output logic              upDrive,
  output logic [NUM_DN-1:0] dnDrive,
  output logic [NUM_DN-1:0] lsSel,
  output line_t             repLine,
  output logic [FRAME_W-1:0] frameCnt
);
  line_t srcLine;
  logic [1:0] se0Cnt;
  logic act;

  assign act     = ctl.actDown || ctl.actUp;
  assign srcLine = ctl.actDown ? upLine : dnLine[2*int'(ctl.srcIdx) +: 2];
  assign eop     = act && (srcLine == ctl.srcIdle) && (se0Cnt == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      se0Cnt  <= '0;
      upDrive <= 1'b0;
      dnDrive <= '0;
      lsSel   <= '0;
      repLine <= LINE_DPH;
    end else begin
      if (act && srcLine == LINE_SE0) se0Cnt <= (se0Cnt == 2'd2) ? 2'd2 : se0Cnt + 2'd1;
      else se0Cnt <= '0;
      upDrive <= ctl.actUp;
      dnDrive <= ctl.dnMask;
      lsSel   <= ctl.lsMask;
      repLine <= act ? srcLine : LINE_DPH;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || sofStrobe) frameCnt <= '0;
    else if (frameCnt == FRAME_W'(FRAME_LEN - 1)) frameCnt <= '0;
    else frameCnt <= frameCnt + 1'b1;
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    !(upDrive && (|dnDrive)));                                    // R7
  AST_LS_SEL_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (lsSel & ~dnDrive) == '0);                                    // R5
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |=> (frameCnt == '0));                              // R11
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= FRAME_W'(FRAME_LEN - 1));                         // R11
endmodule

// File: rtl/hub_repeater.sv
module hub_repeater
  import hubRptPkg::*;
#(
  parameter int FRAME_LEN = 12000,
  localparam int FRAME_W = $clog2(FRAME_LEN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          upLine,
  input  logic [2*NUM_DN-1:0] dnLine,
  input  logic [NUM_DN-1:0]   portEn,
  input  logic                preStrobe,
  input  logic                sofStrobe,
  output logic                upDrive,
  output logic [NUM_DN-1:0]   dnDrive,
  output logic [NUM_DN-1:0]   lsSel,
  output logic [1:0]          repLine,
  output logic [FRAME_W-1:0]  frameCnt
);
  ctlStrobe_t ctl;
  logic eop;

  hubRptCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .upLine(upLine), .dnLine(dnLine), .portEn(portEn),
    .preStrobe(preStrobe), .eop(eop), .ctl(ctl)
  );

  hubRptData #(.FRAME_LEN(FRAME_LEN)) u_data (
    .clk(clk), .rstN(rstN), .upLine(upLine), .dnLine(dnLine), .sofStrobe(sofStrobe),
    .ctl(ctl), .eop(eop), .upDrive(upDrive), .dnDrive(dnDrive), .lsSel(lsSel),
    .repLine(repLine), .frameCnt(frameCnt)
  );
endmodule

// File: tb/hub_repeater_bench.sv
`timescale 1ns/1ps
module hub_repeater_bench;
  localparam int FL = 40;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] up = 2'b10;
  logic [1:0] dn [4];
  logic [3:0] portEn = 4'b0000;
  logic preStrobe = 1'b0, sofStrobe = 1'b0;
  logic upDrive;
  logic [3:0] dnDrive, lsSel;
  logic [1:0] repLine;
  logic [$clog2(FL)-1:0] frameCnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hub_repeater #(.FRAME_LEN(FL)) u_hub_repeater (
    .clk(clk), .rstN(rstN), .upLine(up), .dnLine({dn[3], dn[2], dn[1], dn[0]}),
    .portEn(portEn), .preStrobe(preStrobe), .sofStrobe(sofStrobe),
    .upDrive(upDrive), .dnDrive(dnDrive), .lsSel(lsSel), .repLine(repLine),
    .frameCnt(frameCnt)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic eu, logic [3:0] ed, logic [3:0] el, logic [1:0] er);
    checks++;
    if (upDrive !== eu || dnDrive !== ed || lsSel !== el || repLine !== er) begin
      errors++;
      $display("FAIL %s: actual up=%b dn=%b ls=%b rep=%b expected up=%b dn=%b ls=%b rep=%b",
               req, upDrive, dnDrive, lsSel, repLine, eu, ed, el, er);
    end
  endtask

  task automatic chkFrame(string req, int exp);
    checks++;
    if (int'(frameCnt) != exp) begin
      errors++;
      $display("FAIL %s: actual frame=%0d expected frame=%0d", req, frameCnt, exp);
    end
  endtask

  task automatic upEop();
    up = 2'b00; step(); step(); up = 2'b10; step(); step();
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", 1'b0, 4'b0000, 4'b0000, 2'b10);
    chkFrame("R1 reset frame", 0);
  endtask

  task automatic t_down();
    up = 2'b01; step(); chk("R3 downstream start", 0, 4'b0101, 4'b0000, 2'b01);
    up = 2'b10; step(); chk("R4 low-speed port silent", 0, 4'b0101, 4'b0000, 2'b10);
    up = 2'b00; step(); chk("R3 SE0 repeated", 0, 4'b0101, 4'b0000, 2'b00);
    up = 2'b10; step(); chk("R6 single SE0 is no EOP", 0, 4'b0101, 4'b0000, 2'b10);
    up = 2'b00; step(); step(); up = 2'b10; step();
    chk("R6 EOP idle bit repeated", 0, 4'b0101, 4'b0000, 2'b10);
    step(); chk("R6 drivers off after EOP", 0, 4'b0000, 4'b0000, 2'b10);
  endtask

  task automatic t_pre();
    up = 2'b01; step();
    preStrobe = 1'b1; step(); preStrobe = 1'b0;
    chk("R5 low-speed opened after preamble", 0, 4'b0111, 4'b0010, 2'b01);
    up = 2'b10; step(); chk("R5 gate held", 0, 4'b0111, 4'b0010, 2'b10);
    up = 2'b00; step(); step(); up = 2'b10; step();
    chk("R6 low-speed keeps EOP idle bit", 0, 4'b0111, 4'b0010, 2'b10);
    step(); chk("R6 all off after low-speed EOP", 0, 4'b0000, 4'b0000, 2'b10);
    up = 2'b01; step(); chk("R6 gate closed for next packet", 0, 4'b0101, 4'b0000, 2'b01);
    upEop();
  endtask

  task automatic t_preIdle();
    preStrobe = 1'b1; step(); preStrobe = 1'b0;
    chk("R12 idle preamble no drive", 0, 4'b0000, 4'b0000, 2'b10);
    up = 2'b01; step(); chk("R12 idle preamble ignored", 0, 4'b0101, 4'b0000, 2'b01);
    upEop();
  endtask

  task automatic t_up();
    dn[2] = 2'b01; step(); chk("R7 upstream start", 1, 4'b0000, 4'b0000, 2'b01);
    dn[2] = 2'b10; dn[0] = 2'b01; step(); chk("R8 other port ignored", 1, 4'b0000, 4'b0000, 2'b10);
    dn[2] = 2'b00; step(); step(); dn[2] = 2'b10; step();
    chk("R7 upstream EOP idle bit", 1, 4'b0000, 4'b0000, 2'b10);
    step(); chk("R9 quiet bit after EOP", 0, 4'b0000, 4'b0000, 2'b10);
    step(); chk("R9 new owner after quiet bit", 1, 4'b0000, 4'b0000, 2'b01);
    dn[0] = 2'b00; step(); step(); dn[0] = 2'b10; step(); step(); step();
    chk("R9 idle again", 0, 4'b0000, 4'b0000, 2'b10);
  endtask

  task automatic t_prio();
    dn[0] = 2'b01; dn[2] = 2'b00; step();
    chk("R8 lowest index owns", 1, 4'b0000, 4'b0000, 2'b01);
    dn[2] = 2'b10; dn[0] = 2'b00; step(); step(); dn[0] = 2'b10; step(); step(); step();
    chk("R8 session closed", 0, 4'b0000, 4'b0000, 2'b10);
  endtask

  task automatic t_lsUp();
    dn[1] = 2'b10; step(); chk("R7 low-speed port leaves its idle", 1, 4'b0000, 4'b0000, 2'b10);
    dn[1] = 2'b00; step(); step(); dn[1] = 2'b01; step();
    chk("R7 low-speed EOP to D- high", 1, 4'b0000, 4'b0000, 2'b01);
    step(); chk("R9 quiet after low-speed EOP", 0, 4'b0000, 4'b0000, 2'b10);
    step();
  endtask

  task automatic t_hostWins();
    up = 2'b01; dn[0] = 2'b01; step();
    chk("R10 host wins", 0, 4'b0101, 4'b0000, 2'b01);
    dn[0] = 2'b10; upEop();
    chk("R10 closed", 0, 4'b0000, 4'b0000, 2'b10);
  endtask

  task automatic t_hold();
    dn[3] = 2'b10; step(); chk("R2 unattached enabled port ignored", 0, 4'b0000, 4'b0000, 2'b10);
    up = 2'b01; step(); chk("R2 class held while enabled", 0, 4'b0101, 4'b0000, 2'b01);
    upEop();
    portEn[3] = 1'b0; step();
    portEn[3] = 1'b1; up = 2'b01; step();
    chk("R2 reclassified while disabled", 0, 4'b1101, 4'b0000, 2'b01);
    upEop();
  endtask

  task automatic t_frame();
    sofStrobe = 1'b1; step(); sofStrobe = 1'b0;
    chkFrame("R11 SOF clears", 0);
    repeat (5) step(); chkFrame("R11 counting", 5);
    repeat (34) step(); chkFrame("R11 last value", FL - 1);
    step(); chkFrame("R11 wrap", 0);
  endtask

  initial begin
    dn[0] = 2'b10; dn[1] = 2'b01; dn[2] = 2'b10; dn[3] = 2'b00;
    repeat (3) step();
    t_reset();
    rstN = 1'b1;
    step(); step();
    portEn = 4'b1111;
    step();
    t_down();
    t_pre();
    t_preIdle();
    t_up();
    t_prio();
    t_lsUp();
    t_hostWins();
    t_hold();
    t_frame();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule